// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

This block decides whether a processor core should take an interrupt. It holds a software interrupt request register and a current priority-level register. Software fills both through simple write strobes. On an evaluate strobe it combines the software requests with a bank of external interrupt lines and resolves one winning level. It raises an interrupt only when that level is above the current priority. When it takes an interrupt, it latches the winning level into an ID register and every pending source into a summary register, so a handler can read both.

Software request bits 4 to 18 map to levels 1 to 15. A software request at bit i has level i-3. External lines 20 to 31 map to levels equal to their bit index. Any pending external line outranks every software request.

Evaluation is one-shot. The block comes out of reset armed. Each evaluation disarms it, and the core re-arms it by signalling a return from exception.

Top module: `irq_level_resolver`

## Requirements
- R1: A write to the software request register (sw_wr) stores only bits 4..18 of sw_wdata (mask 0x7FFF0). All other bits read back as zero on swreq_o from the next cycle.
- R2: A write to the priority-level register (ipl_wr) stores only the low 5 bits of ipl_wdata. The stored value is visible on ipl_o from the next cycle.
- R3: The software level is i-3, where i is the highest set bit of the software request register. It is 0 when no software bit is set.
- R4: An external line at bit i, for i from 20 to 31, has level i. Any pending external line replaces the software level with the highest external level. External lines 0..19 are ignored: they give no level and no summary bit.
- R5: An interrupt is taken only if the resolved level is nonzero and strictly greater than the priority-level register, as sampled in the evaluating cycle.
- R6: When an interrupt is taken, take_o is high for exactly the one cycle after the evaluating cycle. In that same cycle, intid_o shows the resolved level. summary_o shows every pending software bit and every pending external line 20..31, each at its own bit position.
- R7: When no interrupt is taken, summary_o and intid_o keep their previous values.
- R8: An evaluation happens only in a cycle where eval is high and the block is armed. Reset and exc_return arm the block, and every evaluation disarms it, whether or not it takes an interrupt.
- R9: After reset, take_o, summary_o, intid_o, ipl_o and swreq_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Write strobe for the software request register |
| sw_wdata | input | 32 | Software request write data |
| ipl_wr | input | 1 | Write strobe for the priority-level register |
| ipl_wdata | input | 32 | Priority-level write data |
| ext_irq | input | 32 | External interrupt lines |
| eval | input | 1 | Evaluate strobe |
| exc_return | input | 1 | Return-from-exception, re-arms evaluation |
| take_o | output | 1 | One-cycle take-interrupt pulse |
| summary_o | output | 32 | Latched summary of pending sources |
| intid_o | output | 5 | Latched winning level |
| ipl_o | output | 5 | Current priority level |
| swreq_o | output | 32 | Current software request register |

## Verification
The assertions check the following on every cycle:
- register writes keep only their allowed bits;
- a taken level is always above the priority that was current when it was evaluated;
- take_o never lasts two cycles;
- summary and ID stay unchanged whenever no interrupt is taken.

Only the bench's scenarios can show that the level mapping is right. This covers software bit offsets, external bit indices, external priority over software, and ignored low external lines. The scenarios also cover the exact summary contents, the strict comparison at equal priority, and the arming sequence across exc_return.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
    localparam int IRQ_W = 32;
    localparam int LVL_W = 5;

    typedef struct packed {
        logic [IRQ_W-1:0] swreq;
        logic [LVL_W-1:0] ipl;
        logic [IRQ_W-1:0] summary;
        logic [LVL_W-1:0] intid;
        logic             take;
        logic             armed;
    } res_state_t;
endpackage

// File: rtl/irq_scan.sv
module irq_scan #(
    parameter int W     = 32,
    parameter int LVL_W = 5,
    parameter int LO    = 4,
    parameter int HI    = 18,
    parameter int BASE  = 1
) (
    input  logic [W-1:0]     req,
    output logic [LVL_W-1:0] level,
    output logic [W-1:0]     hits
);
    localparam logic [W-1:0] RANGE =
        W'(((64'd1 << (HI + 1)) - 64'd1) & ~((64'd1 << LO) - 64'd1));

    logic unused_req;
    assign unused_req = ^(req & ~RANGE);

    // ascending scan: the last (highest) set bit wins
    always_comb begin
        level = '0;
        hits  = '0;
        for (int i = LO; i <= HI; i++) begin
            if (req[i]) begin
                level   = LVL_W'(i - LO + BASE);
                hits[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] sw_level,
    input  logic [LVL_W-1:0] ext_level,
    input  logic [LVL_W-1:0] ipl,
    output logic [LVL_W-1:0] level,
    output logic             fire
);
    always_comb begin
        level = (ext_level != '0) ? ext_level : sw_level;
        fire  = (level != '0) && (level > ipl);
    end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
    import irq_res_pkg::*;
#(
    parameter int SW_LO  = 4,
    parameter int SW_HI  = 18,
    parameter int EXT_LO = 20,
    parameter int EXT_HI = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr,
    input  logic [IRQ_W-1:0] sw_wdata,
    input  logic             ipl_wr,
    input  logic [IRQ_W-1:0] ipl_wdata,
    input  logic [IRQ_W-1:0] ext_irq,
    input  logic             eval,
    input  logic             exc_return,
    output logic             take_o,
    output logic [IRQ_W-1:0] summary_o,
    output logic [LVL_W-1:0] intid_o,
    output logic [LVL_W-1:0] ipl_o,
    output logic [IRQ_W-1:0] swreq_o
);
    localparam logic [IRQ_W-1:0] SW_MASK =
        IRQ_W'(((64'd1 << (SW_HI + 1)) - 64'd1) & ~((64'd1 << SW_LO) - 64'd1));

    res_state_t st_d, st_q;

    logic [LVL_W-1:0] sw_level, ext_level, win_level;
    logic [IRQ_W-1:0] sw_hits, ext_hits;
    logic             fire;

    logic unused_ipl;
    assign unused_ipl = ^ipl_wdata[IRQ_W-1:LVL_W];

    irq_scan #(.W(IRQ_W), .LVL_W(LVL_W), .LO(SW_LO), .HI(SW_HI), .BASE(1)) u_sw_scan (
        .req   (st_q.swreq),
        .level (sw_level),
        .hits  (sw_hits)
    );

    irq_scan #(.W(IRQ_W), .LVL_W(LVL_W), .LO(EXT_LO), .HI(EXT_HI), .BASE(EXT_LO)) u_ext_scan (
        .req   (ext_irq),
        .level (ext_level),
        .hits  (ext_hits)
    );

    irq_pick #(.LVL_W(LVL_W)) u_pick (
        .sw_level  (sw_level),
        .ext_level (ext_level),
        .ipl       (st_q.ipl),
        .level     (win_level),
        .fire      (fire)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        if (sw_wr)
            st_d.swreq = sw_wdata & SW_MASK;
        if (ipl_wr)
            st_d.ipl = ipl_wdata[LVL_W-1:0];
        if (eval && st_q.armed) begin
            st_d.armed = 1'b0;
            if (fire) begin
                st_d.take    = 1'b1;
                st_d.summary = sw_hits | ext_hits;
                st_d.intid   = win_level;
            end
        end
        if (exc_return)
            st_d.armed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o    = st_q.take;
    assign summary_o = st_q.summary;
    assign intid_o   = st_q.intid;
    assign ipl_o     = st_q.ipl;
    assign swreq_o   = st_q.swreq;
endmodule

// File: rtl/irq_level_resolver_chk.sv
module irq_level_resolver_chk
    import irq_res_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sw_wr,
    input logic [IRQ_W-1:0] sw_wdata,
    input logic             ipl_wr,
    input logic [IRQ_W-1:0] ipl_wdata,
    input logic             take_o,
    input logic [IRQ_W-1:0] summary_o,
    input logic [LVL_W-1:0] intid_o,
    input logic [LVL_W-1:0] ipl_o,
    input logic [IRQ_W-1:0] swreq_o
);
    a_r1_sw_masked: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> swreq_o == ($past(sw_wdata) & 32'h0007_FFF0));

    a_r2_ipl_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ipl_wr |=> ipl_o == $past(ipl_wdata[LVL_W-1:0]));

    a_r5_above_priority: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (intid_o != '0) && (intid_o > $past(ipl_o)));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> $stable(summary_o) && $stable(intid_o));
endmodule

bind irq_level_resolver irq_level_resolver_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_wr     (sw_wr),
    .sw_wdata  (sw_wdata),
    .ipl_wr    (ipl_wr),
    .ipl_wdata (ipl_wdata),
    .take_o    (take_o),
    .summary_o (summary_o),
    .intid_o   (intid_o),
    .ipl_o     (ipl_o),
    .swreq_o   (swreq_o)
);

// File: tb/irq_level_resolver_bench.sv
module irq_level_resolver_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr = 1'b0, ipl_wr = 1'b0, eval = 1'b0, exc_return = 1'b0;
    logic [31:0] sw_wdata = '0, ipl_wdata = '0, ext_irq = '0;
    logic        take_o;
    logic [31:0] summary_o, swreq_o;
    logic [4:0]  intid_o, ipl_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_level_resolver u_irq_level_resolver (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .ipl_wr(ipl_wr), .ipl_wdata(ipl_wdata), .ext_irq(ext_irq),
        .eval(eval), .exc_return(exc_return), .take_o(take_o),
        .summary_o(summary_o), .intid_o(intid_o), .ipl_o(ipl_o),
        .swreq_o(swreq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_sw(input logic [31:0] v);
        @(negedge clk); sw_wr = 1'b1; sw_wdata = v;
        @(negedge clk); sw_wr = 1'b0;
    endtask

    task automatic write_ipl(input logic [31:0] v);
        @(negedge clk); ipl_wr = 1'b1; ipl_wdata = v;
        @(negedge clk); ipl_wr = 1'b0;
    endtask

    task automatic rearm();
        @(negedge clk); exc_return = 1'b1;
        @(negedge clk); exc_return = 1'b0;
    endtask

    // strobe eval for one cycle; outputs are sampled one cycle later
    task automatic evaluate(input string req, input logic exp_take,
                            input logic [31:0] exp_sum, input logic [4:0] exp_id);
        @(negedge clk); eval = 1'b1;
        @(negedge clk); eval = 1'b0;
        chk(req, {31'd0, take_o}, {31'd0, exp_take});
        chk(req, summary_o, exp_sum);
        chk(req, {27'd0, intid_o}, {27'd0, exp_id});
        @(negedge clk);
        chk({req, " pulse"}, {31'd0, take_o}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R9 take", {31'd0, take_o}, 32'd0);
        chk("R9 summary", summary_o, 32'd0);
        chk("R9 intid", {27'd0, intid_o}, 32'd0);
        chk("R9 ipl", {27'd0, ipl_o}, 32'd0);
        chk("R9 swreq", swreq_o, 32'd0);
    endtask

    task automatic t_masks();
        write_sw(32'hFFFF_FFFF);
        chk("R1 sw mask", swreq_o, 32'h0007_FFF0);
        write_ipl(32'h0000_00FF);
        chk("R2 ipl mask", {27'd0, ipl_o}, 32'h1F);
        write_ipl(32'h0);
        write_sw(32'h0);
    endtask

    task automatic t_software();
        // bits 4 and 9 set: highest is bit 9 -> level 6 (R3)
        write_sw(32'h0000_0210);
        evaluate("R3 sw level", 1'b1, 32'h0000_0210, 5'd6);
        rearm();
        // bit 18 -> level 15
        write_sw(32'h0004_0000);
        evaluate("R3 top sw level", 1'b1, 32'h0004_0000, 5'd15);
        rearm();
    endtask

    task automatic t_external();
        // sw bit 18, ext bit 22 and ignored ext bit 5 -> level 22 (R4, R6)
        write_sw(32'h0004_0010);
        @(negedge clk); ext_irq = 32'h0040_0020;
        evaluate("R4 ext overrides", 1'b1, 32'h0044_0010, 5'd22);
        rearm();
        // only low ext lines: no level from them, sw bit 18 gives 15
        @(negedge clk); ext_irq = 32'h000F_FFFF;
        evaluate("R4 low ext ignored", 1'b1, 32'h0004_0010, 5'd15);
        rearm();
        @(negedge clk); ext_irq = 32'h8010_0000;
        evaluate("R4 ext bit31", 1'b1, 32'h8014_0010, 5'd31);
        rearm();
    endtask

    task automatic t_priority();
        write_sw(32'h0);
        @(negedge clk); ext_irq = 32'h0040_0000;
        write_ipl(32'd22);
        // equal level: not taken, summary/id hold (R5, R7)
        evaluate("R5 equal not taken", 1'b0, 32'h8014_0010, 5'd31);
        rearm();
        write_ipl(32'd21);
        evaluate("R5 above taken", 1'b1, 32'h0040_0000, 5'd22);
        rearm();
        write_ipl(32'd0);
        @(negedge clk); ext_irq = 32'h0;
        evaluate("R7 nothing pending", 1'b0, 32'h0040_0000, 5'd22);
        rearm();
    endtask

    task automatic t_arming();
        write_sw(32'h0000_0100);  // bit 8 -> level 5
        evaluate("R8 armed eval", 1'b1, 32'h0000_0100, 5'd5);
        write_sw(32'h0000_1000);  // bit 12 -> level 9
        evaluate("R8 disarmed eval", 1'b0, 32'h0000_0100, 5'd5);
        rearm();
        evaluate("R8 rearmed eval", 1'b1, 32'h0000_1000, 5'd9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_software();
        t_external();
        t_priority();
        t_arming();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule